// File: doc/BRIEF.md
# Message Transmit Length Launcher

This block is the processor-facing start control for the transmit side of a byte-oriented serial message link. Software first loads the message body into a small transmit byte store. It then writes the body length into a length register, and that write is itself the start command. The block checks the length and raises a one-cycle start request toward a serializer. While the serializer works through the message, the block moves a byte read pointer through the store. It clears the length register as soon as the serializer reports that the transfer has ended.

A length of zero, or any length above the store depth, is dropped without any response. A length write during a transfer is ignored, and the message in flight is not affected. A length write made while the abort-request bit is set is refused and raises a protocol-error pulse. Because the register reads back the pending length until the end of the transfer, software can poll it for zero to learn that the transmitter is free. Bit encoding, arbitration and CRC are the serializer's job, and this block does none of them.

Top module: `tx_len_launcher`

## Requirements
- R1: After a synchronous reset, `len_rd`, `busy`, `start_pulse`, `proto_err`, `last_byte` and `rd_ptr` are all zero.
- R2: When idle with `abort_req` low, a length write of 1 to MAX_LEN (default 11) is accepted. On the next cycle `len_rd` equals the written value, `busy` is 1 and `start_pulse` is 1 for exactly one cycle.
- R3: When idle, a length write of 0 or of any value above MAX_LEN is dropped. `busy` and `start_pulse` stay 0, `len_rd` stays 0 and no flag is raised.
- R4: On acceptance `rd_ptr` starts at 0. Each `byte_taken` strobe during a transfer advances it by one, and it holds at length-1. `last_byte` is 1 exactly when the block is busy and `rd_ptr` equals length-1.
- R5: `tx_byte` always shows the store entry at `rd_ptr`. An entry that was not rewritten since an earlier message is sent with its old value.
- R6: A `ser_done` strobe during a transfer ends it, whatever the outcome (success, failure or abort). On the next cycle `len_rd` is 0, `busy` is 0 and `rd_ptr` is 0.
- R7: A length write during a transfer is ignored. `len_rd` and `rd_ptr` keep their values and no new `start_pulse` appears.
- R8: A length write while `abort_req` is 1 is never accepted. On the next cycle `proto_err` is 1 for one cycle, with no `start_pulse` and no change to `len_rd`.
- R9: `ser_abort` is 1 exactly when `abort_req` is 1 and a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| len_wr_en | input | 1 | Length register write strobe |
| len_wr_data | input | LEN_W | Written body length |
| abort_req | input | 1 | Abort-request bit from the control register |
| buf_wr_en | input | 1 | Transmit store write strobe |
| buf_wr_addr | input | LEN_W | Store entry index; indices at or above MAX_LEN are ignored |
| buf_wr_data | input | BYTE_W | Byte written to the store |
| byte_taken | input | 1 | Serializer has consumed the current byte |
| ser_done | input | 1 | Serializer reports the end of the transfer (any outcome) |
| len_rd | output | LEN_W | Length register readback, 0 when idle |
| busy | output | 1 | Transfer in progress |
| start_pulse | output | 1 | One-cycle start request to the serializer |
| ser_abort | output | 1 | Abort request forwarded to the serializer |
| rd_ptr | output | LEN_W | Index of the byte currently offered |
| last_byte | output | 1 | Current byte is the final body byte |
| tx_byte | output | BYTE_W | Byte at the read pointer |
| proto_err | output | 1 | One-cycle pulse for a length write during an abort request |

## Verification
On every cycle the assertions check the following. The start pulse lasts one cycle and only comes with an in-range length. The pointer stays below the length and steps by one per strobe. The register holds steady during a transfer and clears one cycle after `ser_done`. Refused writes never start anything, and both the abort forwarding and the protocol-error pulse follow their rule. Two things only the bench scenarios can show: that every length from 0 to 15 gets the right accept or refuse decision, and that the offered bytes match the store contents, including stale entries kept from an earlier message.

// File: rtl/tx_len_pkg.sv
package tx_len_pkg;

    // Default store depth and byte width
    localparam int unsigned MAX_LEN_DEF = 11;
    localparam int unsigned BYTE_W_DEF  = 8;

    typedef enum logic {
        TXS_IDLE = 1'b0,
        TXS_RUN  = 1'b1
    } txs_state_e;

    // Length write request as seen by the control FSM
    typedef struct packed {
        logic valid;
        logic blocked;
        logic in_range;
    } len_req_t;

    function automatic logic len_in_range(int unsigned value, int unsigned max_len);
        return (value != 0) && (value <= max_len);
    endfunction

endpackage

// File: rtl/tx_len_ctrl.sv
module tx_len_ctrl
    import tx_len_pkg::*;
#(
    parameter int unsigned MAX_LEN = MAX_LEN_DEF,
    parameter int unsigned LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] wr_data,
    input  logic             abort_req,
    input  logic             done,
    output logic [LEN_W-1:0] len_q,
    output logic             busy,
    output logic             start_pulse,
    output logic             proto_err,
    output logic             accept,
    output logic             finish
);

    txs_state_e state_q;
    len_req_t   req;

    always_comb begin
        req.valid    = wr_en;
        req.blocked  = abort_req;
        req.in_range = len_in_range(int'(wr_data), MAX_LEN);
    end

    assign accept = req.valid && !req.blocked && req.in_range && (state_q == TXS_IDLE);
    assign finish = (state_q == TXS_RUN) && done;
    assign busy   = (state_q == TXS_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= TXS_IDLE;
            len_q       <= '0;
            start_pulse <= 1'b0;
            proto_err   <= 1'b0;
        end else begin
            start_pulse <= accept;
            proto_err   <= req.valid && req.blocked;
            unique case (state_q)
                TXS_IDLE: begin
                    if (accept) begin
                        len_q   <= wr_data;
                        state_q <= TXS_RUN;
                    end
                end
                TXS_RUN: begin
                    if (done) begin
                        len_q   <= '0;
                        state_q <= TXS_IDLE;
                    end
                end
                default: state_q <= TXS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tx_byte_ptr.sv
module tx_byte_ptr #(
    parameter int unsigned LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             finish,
    input  logic             busy,
    input  logic             byte_taken,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] ptr,
    output logic             last
);

    logic [LEN_W-1:0] final_idx;

    assign final_idx = len - 1'b1;
    assign last      = busy && (ptr == final_idx);

    always_ff @(posedge clk) begin
        if (rst || finish || restart) begin
            ptr <= '0;
        end else if (busy && byte_taken && !last) begin
            ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/tx_byte_store.sv
module tx_byte_store #(
    parameter int unsigned DEPTH  = 11,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned AW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data
);

    logic [DEPTH-1:0][BYTE_W-1:0] entries;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && (wr_addr == AW'(g))) begin
                q <= wr_data;
            end
        end
        assign entries[g] = q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_addr == AW'(i)) begin
                rd_data = entries[i];
            end
        end
    end

endmodule

// File: rtl/tx_len_launcher.sv
module tx_len_launcher
    import tx_len_pkg::*;
#(
    parameter int unsigned MAX_LEN = MAX_LEN_DEF,
    parameter int unsigned BYTE_W  = BYTE_W_DEF,
    localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              len_wr_en,
    input  logic [LEN_W-1:0]  len_wr_data,
    input  logic              abort_req,
    input  logic              buf_wr_en,
    input  logic [LEN_W-1:0]  buf_wr_addr,
    input  logic [BYTE_W-1:0] buf_wr_data,
    input  logic              byte_taken,
    input  logic              ser_done,
    output logic [LEN_W-1:0]  len_rd,
    output logic              busy,
    output logic              start_pulse,
    output logic              ser_abort,
    output logic [LEN_W-1:0]  rd_ptr,
    output logic              last_byte,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              proto_err
);

    logic accept;
    logic finish;

    tx_len_ctrl #(
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (len_wr_en),
        .wr_data     (len_wr_data),
        .abort_req   (abort_req),
        .done        (ser_done),
        .len_q       (len_rd),
        .busy        (busy),
        .start_pulse (start_pulse),
        .proto_err   (proto_err),
        .accept      (accept),
        .finish      (finish)
    );

    tx_byte_ptr #(
        .LEN_W (LEN_W)
    ) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .restart    (accept),
        .finish     (finish),
        .busy       (busy),
        .byte_taken (byte_taken),
        .len        (len_rd),
        .ptr        (rd_ptr),
        .last       (last_byte)
    );

    tx_byte_store #(
        .DEPTH  (MAX_LEN),
        .BYTE_W (BYTE_W),
        .AW     (LEN_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (buf_wr_en),
        .wr_addr (buf_wr_addr),
        .wr_data (buf_wr_data),
        .rd_addr (rd_ptr),
        .rd_data (tx_byte)
    );

    assign ser_abort = abort_req && busy;

endmodule

// File: rtl/tx_len_launcher_chk.sv
module tx_len_launcher_chk #(
    parameter int unsigned MAX_LEN = 11,
    parameter int unsigned BYTE_W  = 8,
    localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              len_wr_en,
    input logic [LEN_W-1:0]  len_wr_data,
    input logic              abort_req,
    input logic              byte_taken,
    input logic              ser_done,
    input logic [LEN_W-1:0]  len_rd,
    input logic              busy,
    input logic              start_pulse,
    input logic              ser_abort,
    input logic [LEN_W-1:0]  rd_ptr,
    input logic              last_byte,
    input logic              proto_err
);

    logic bad_len;
    assign bad_len = (len_wr_data == '0) || (len_wr_data > LEN_W'(MAX_LEN));

    p_start_once_r2: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    p_start_valid_r2: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> busy && (len_rd != '0) && (len_rd <= LEN_W'(MAX_LEN)));

    p_refuse_r3: assert property (@(posedge clk) disable iff (rst)
        !busy && len_wr_en && bad_len |=> !busy && !start_pulse);

    p_ptr_bound_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> rd_ptr < len_rd);

    p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
        busy && byte_taken && !ser_done && !last_byte |=> rd_ptr == LEN_W'($past(rd_ptr) + 1'b1));

    p_done_clear_r6: assert property (@(posedge clk) disable iff (rst)
        busy && ser_done |=> !busy && (len_rd == '0) && (rd_ptr == '0));

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (len_rd == '0) && !last_byte);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        busy && !ser_done |=> $stable(len_rd) && !start_pulse);

    p_abort_err_r8: assert property (@(posedge clk) disable iff (rst)
        len_wr_en && abort_req |=> proto_err && !start_pulse);

    p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> $past(len_wr_en && abort_req));

    p_fwd_abort_r9: assert property (@(posedge clk) disable iff (rst)
        ser_abort |-> busy && abort_req);

endmodule

bind tx_len_launcher tx_len_launcher_chk #(
    .MAX_LEN (MAX_LEN),
    .BYTE_W  (BYTE_W)
) u_chk (.*);

// File: tb/sim_tx_len_launcher.sv
module sim_tx_len_launcher;

    localparam int CLK_PERIOD = 10;
    localparam int MAXL = 11;
    localparam int LW   = 4;
    localparam int BW   = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          len_wr_en = 1'b0;
    logic [LW-1:0] len_wr_data = '0;
    logic          abort_req = 1'b0;
    logic          buf_wr_en = 1'b0;
    logic [LW-1:0] buf_wr_addr = '0;
    logic [BW-1:0] buf_wr_data = '0;
    logic          byte_taken = 1'b0;
    logic          ser_done = 1'b0;
    logic [LW-1:0] len_rd;
    logic          busy;
    logic          start_pulse;
    logic          ser_abort;
    logic [LW-1:0] rd_ptr;
    logic          last_byte;
    logic [BW-1:0] tx_byte;
    logic          proto_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [BW-1:0] exp_buf [MAXL];

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_len_launcher u0 (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put_byte(input int idx, input logic [BW-1:0] val);
        buf_wr_en   = 1'b1;
        buf_wr_addr = LW'(idx);
        buf_wr_data = val;
        step();
        buf_wr_en = 1'b0;
        if (idx < MAXL) exp_buf[idx] = val;
    endtask

    task automatic write_len(input int v);
        len_wr_en   = 1'b1;
        len_wr_data = LW'(v);
        step();
        len_wr_en = 1'b0;
    endtask

    task automatic take();
        byte_taken = 1'b1;
        step();
        byte_taken = 1'b0;
    endtask

    task automatic finish_msg();
        ser_done = 1'b1;
        step();
        ser_done = 1'b0;
        chk(busy == 1'b0, "R6 busy after done", int'(busy), 0);
        chk(len_rd == '0, "R6 len after done", int'(len_rd), 0);
        chk(rd_ptr == '0, "R6 ptr after done", int'(rd_ptr), 0);
    endtask

    // Full transfer of length v with byte walk; expects acceptance
    task automatic run_msg(input int v);
        write_len(v);
        chk(busy == 1'b1, "R2 busy", int'(busy), 1);
        chk(int'(len_rd) == v, "R2 len readback", int'(len_rd), v);
        chk(start_pulse == 1'b1, "R2 start", int'(start_pulse), 1);
        step();
        chk(start_pulse == 1'b0, "R2 single start", int'(start_pulse), 0);
        for (int k = 0; k < v; k++) begin
            chk(int'(rd_ptr) == k, "R4 ptr", int'(rd_ptr), k);
            chk(last_byte == (k == v - 1), "R4 last", int'(last_byte), int'(k == v - 1));
            chk(tx_byte == exp_buf[k], "R5 byte", int'(tx_byte), int'(exp_buf[k]));
            take();
        end
        chk(int'(rd_ptr) == v - 1, "R4 ptr saturates", int'(rd_ptr), v - 1);
        chk(int'(len_rd) == v, "R6 len held until done", int'(len_rd), v);
        finish_msg();
    endtask

    initial begin
        repeat (3) step();
        chk(len_rd == '0 && busy == 1'b0 && start_pulse == 1'b0 && proto_err == 1'b0
            && rd_ptr == '0 && last_byte == 1'b0, "R1 reset state", int'(len_rd), 0);
        rst = 1'b0;
        step();

        for (int i = 0; i < MAXL; i++) put_byte(i, BW'(8'h3C + i * 17));
        put_byte(12, 8'hFF);

        // Exhaustive length sweep
        for (int v = 0; v < 16; v++) begin
            if (v >= 1 && v <= MAXL) begin
                run_msg(v);
            end else begin
                write_len(v);
                chk(busy == 1'b0, "R3 refused busy", int'(busy), 0);
                chk(start_pulse == 1'b0, "R3 refused start", int'(start_pulse), 0);
                chk(len_rd == '0, "R3 refused len", int'(len_rd), 0);
                chk(proto_err == 1'b0, "R3 no flag", int'(proto_err), 0);
                step();
            end
        end

        // Stale bytes: refresh only entry 0
        put_byte(0, 8'h5A);
        run_msg(4);

        // Write during transfer is ignored
        write_len(5);
        step();
        take();
        take();
        write_len(3);
        chk(int'(len_rd) == 5, "R7 len kept", int'(len_rd), 5);
        chk(int'(rd_ptr) == 2, "R7 ptr kept", int'(rd_ptr), 2);
        chk(start_pulse == 1'b0, "R7 no restart", int'(start_pulse), 0);
        chk(tx_byte == exp_buf[2], "R7 message intact", int'(tx_byte), int'(exp_buf[2]));
        chk(ser_abort == 1'b0, "R9 no abort", int'(ser_abort), 0);
        finish_msg();

        // Abort interlock when idle
        abort_req = 1'b1;
        #1;
        chk(ser_abort == 1'b0, "R9 idle no forward", int'(ser_abort), 0);
        write_len(4);
        chk(busy == 1'b0, "R8 no start", int'(busy), 0);
        chk(len_rd == '0, "R8 len unchanged", int'(len_rd), 0);
        chk(proto_err == 1'b1, "R8 err pulse", int'(proto_err), 1);
        step();
        chk(proto_err == 1'b0, "R8 err one cycle", int'(proto_err), 0);
        abort_req = 1'b0;

        // Abort while busy, then aborted end clears register
        write_len(6);
        take();
        abort_req = 1'b1;
        #1;
        chk(ser_abort == 1'b1, "R9 forward", int'(ser_abort), 1);
        write_len(2);
        chk(proto_err == 1'b1, "R8 err while busy", int'(proto_err), 1);
        chk(int'(len_rd) == 6, "R8 len unchanged busy", int'(len_rd), 6);
        finish_msg();
        chk(ser_abort == 1'b0, "R9 forward ends", int'(ser_abort), 0);
        abort_req = 1'b0;
        step();

        // ser_done while idle has no effect
        ser_done = 1'b1;
        step();
        ser_done = 1'b0;
        chk(busy == 1'b0 && len_rd == '0, "R6 idle done ignored", int'(busy), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule